// File: doc/BRIEF.md
# Host-Memory Block DMA Engine

This block copies a run of bytes between host memory and a 4096-byte buffer inside the device. Software sets up four memory-mapped registers: a host-or-device source address, a destination address, a byte count and a command word. Then it sets the command's go bit and polls that bit until it reads back as zero. The direction bit in the command word decides which of the two addresses is the host side. The device buffer is reached at device addresses from 0x40000 up to 0x40FFF. The engine drives a single-byte valid/ready host port. It writes into or reads from its internal buffer, and it can post an interrupt cause of 0x100 when a transfer completes.

Before any data moves, the engine checks the transfer. The device-side range must lie wholly inside the buffer, and the host-side range must lie below the DMA address limit, which is 2^28 bytes by default and set by a parameter. If either check fails, the transfer is dropped.

The control state machine has six states:
- ST_IDLE waits for the go bit and moves to ST_CHECK.
- ST_CHECK goes back to ST_IDLE if either range check fails. It goes to ST_DONE if the count is zero. Otherwise it goes to ST_HRD_REQ (direction 0) or ST_HWR_REQ (direction 1).
- ST_HRD_REQ goes to ST_HRD_WAIT when the read request is accepted.
- ST_HRD_WAIT goes back to ST_HRD_REQ when a response arrives with bytes still left. It goes to ST_DONE on the response for the last byte.
- ST_HWR_REQ stays in place while bytes remain. It goes to ST_DONE when the last write is accepted.
- ST_DONE returns to ST_IDLE.

Top module: `dma_blk_mover`

## Requirements
- R1: After reset, every register reads zero, `hm_valid` is low and `irq_valid` is low.
- R2: Registers sit at source 0x80, destination 0x88, count 0x90 and command 0x98. A write with `reg_wide`=1 at one of these offsets replaces all 64 bits. A 4-byte write replaces the low half, or the high half when `reg_addr`[2]=1. A read at offset+4 returns the high half in bits 31:0. The command field occupies bits 2:0. Other offsets read zero.
- R3: Command bit 0 (go) reads 1 from the cycle after it is written until the transfer ends, and 0 afterwards. Host requests appear only while it is set.
- R4: With command bit 1 = 0, the engine reads host bytes at source+i in increasing order and stores byte i at buffer offset destination-0x40000+i.
- R5: With command bit 1 = 1, the engine writes buffer byte (source-0x40000+i) to host address destination+i, in increasing order.
- R6: The count register drops by one on each byte moved and reads zero when a good transfer ends. It never wraps below zero.
- R7: If command bit 2 is set, the engine posts `irq_valid` for exactly one cycle with `irq_cause`=0x100 when the transfer completes. If bit 2 is clear, no interrupt is posted.
- R8: If the device address is below 0x40000, or the device range runs past 0x40000+4096, the engine makes no host request, leaves the count unchanged, posts no interrupt and clears the go bit.
- R9: If any host byte address of the range needs a bit at or above `DMA_ADDR_BITS`, the transfer is rejected in the same way as in R8. A range ending exactly at the limit is accepted.
- R10: While the go bit is set, writes to source, destination, count and command have no effect.
- R11: The host port moves one byte per accepted beat. A request keeps `hm_valid` and `hm_addr` steady until `hm_ready`. A read waits for `hm_rvalid` before the next request.
- R12: A count of zero with valid addresses completes with no host request and still posts the interrupt when bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1 = 8-byte write, 0 = 4-byte write |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| hm_valid | output | 1 | Host request valid |
| hm_write | output | 1 | Host request is a write |
| hm_addr | output | 64 | Host byte address |
| hm_wdata | output | 8 | Host write byte |
| hm_ready | input | 1 | Host accepts the request |
| hm_rvalid | input | 1 | Host read response valid |
| hm_rdata | input | 8 | Host read response byte |
| irq_valid | output | 1 | One-cycle interrupt post |
| irq_cause | output | 16 | Interrupt cause value |

## Verification
The copy paths are swept over lengths of 1, 2, 5, 16 and 33 bytes at buffer offsets 0, 777 and the last legal offset. Each run reads host memory into the buffer and then writes the buffer back to host memory. The host data is a function of the address, so shifted or reordered bytes are caught. The host port stalls `hm_ready` and delays responses in a fixed pattern, which separates correct holding of requests from advancing on stalls. Range cases sit one byte on each side of the buffer end, the buffer start and the 2^28 host limit, which tells off-by-one limit checks apart. Zero-length starts, the interrupt enable and register writes made while busy cover the remaining paths.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HRD_REQ,
        ST_HRD_WAIT,
        ST_HWR_REQ,
        ST_DONE
    } dma_state_e;

    localparam logic [7:0]  OFF_SRC = 8'h80;
    localparam logic [7:0]  OFF_DST = 8'h88;
    localparam logic [7:0]  OFF_CNT = 8'h90;
    localparam logic [7:0]  OFF_CMD = 8'h98;

    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 1;
    localparam int CMD_IRQ = 2;
    localparam int CMD_W   = 3;

    localparam logic [15:0] DONE_CAUSE = 16'h0100;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_wide,
    input  logic [7:0]        reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              cnt_dec,
    input  logic              done_clr,
    output logic [63:0]       src_o,
    output logic [63:0]       dst_o,
    output logic [63:0]       cnt_o,
    output logic [CMD_W-1:0]  cmd_o
);
    logic [63:0]      src_q, dst_q, cnt_q;
    logic [CMD_W-1:0] cmd_q;
    logic             busy, hi;
    logic [4:0]       slot;
    logic [63:0]      word;

    assign busy = cmd_q[CMD_GO];
    assign hi   = reg_addr[2];
    assign slot = reg_addr[7:3];

    function automatic logic [63:0] merge(input logic [63:0] old,
                                          input logic [63:0] wd,
                                          input logic wide,
                                          input logic upper);
        if (wide)       return wd;
        else if (upper) return {wd[31:0], old[31:0]};
        else            return {old[63:32], wd[31:0]};
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
            cmd_q <= '0;
        end else begin
            if (reg_wr && !busy) begin
                if (slot == OFF_SRC[7:3]) src_q <= merge(src_q, reg_wdata, reg_wide && !hi, hi);
                if (slot == OFF_DST[7:3]) dst_q <= merge(dst_q, reg_wdata, reg_wide && !hi, hi);
                if (slot == OFF_CNT[7:3]) cnt_q <= merge(cnt_q, reg_wdata, reg_wide && !hi, hi);
                if (slot == OFF_CMD[7:3] && !hi) cmd_q <= reg_wdata[CMD_W-1:0];
            end
            if (cnt_dec)  cnt_q <= cnt_q - 64'd1;
            if (done_clr) cmd_q[CMD_GO] <= 1'b0;
        end
    end

    always_comb begin
        unique case (slot)
            OFF_SRC[7:3]: word = src_q;
            OFF_DST[7:3]: word = dst_q;
            OFF_CNT[7:3]: word = cnt_q;
            OFF_CMD[7:3]: word = {{(64-CMD_W){1'b0}}, cmd_q};
            default:      word = '0;
        endcase
        reg_rdata = hi ? {32'd0, word[63:32]} : word;
    end

    assign src_o = src_q;
    assign dst_o = dst_q;
    assign cnt_o = cnt_q;
    assign cmd_o = cmd_q;

    assert_busy_src_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && busy && slot == OFF_SRC[7:3]) |=> $stable(src_q));
    assert_busy_dst_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && busy && slot == OFF_DST[7:3]) |=> $stable(dst_q));
    assert_busy_dir_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr) |=> $stable(cmd_q[CMD_IRQ:CMD_DIR]));
endmodule

// File: rtl/dma_buf.sv
module dma_buf #(
    parameter int BUF_BYTES = 4096,
    localparam int AW = $clog2(BUF_BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] off,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [BUF_BYTES];

    always_ff @(posedge clk) begin
        if (we) mem[off] <= wdata;
    end

    assign rdata = mem[off];
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
    import dma_pkg::*;
#(
    parameter int          BUF_BYTES     = 4096,
    parameter logic [63:0] BUF_BASE      = 64'h40000,
    parameter int          DMA_ADDR_BITS = 28,
    localparam int AW = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       src,
    input  logic [63:0]       dst,
    input  logic [63:0]       cnt,
    input  logic [CMD_W-1:0]  cmd,
    output logic              cnt_dec,
    output logic              done_clr,
    output logic              hm_valid,
    output logic              hm_write,
    output logic [63:0]       hm_addr,
    output logic [7:0]        hm_wdata,
    input  logic              hm_ready,
    input  logic              hm_rvalid,
    input  logic [7:0]        hm_rdata,
    output logic              buf_we,
    output logic [AW-1:0]     buf_off,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata,
    output logic              irq_valid,
    output logic [15:0]       irq_cause
);
    localparam logic [63:0] HMASK = (64'd1 << DMA_ADDR_BITS) - 64'd1;
    localparam logic [63:0] BUFSZ = 64'(BUF_BYTES);

    dma_state_e  st, st_nx;
    logic [63:0] host_a, dev_a, dev_rel, host_ptr;
    logic [AW-1:0] dev_ptr;
    logic        dev_ok, host_ok, beat, last;

    // range checks evaluated in ST_CHECK
    always_comb begin
        host_a  = cmd[CMD_DIR] ? dst : src;
        dev_a   = cmd[CMD_DIR] ? src : dst;
        dev_rel = dev_a - BUF_BASE;
        dev_ok  = (dev_a >= BUF_BASE) && (dev_rel <= BUFSZ) && (cnt <= BUFSZ - dev_rel);
        host_ok = ((host_a & ~HMASK) == 64'd0) && (cnt <= HMASK - host_a + 64'd1);
    end

    assign beat = (st == ST_HRD_WAIT && hm_rvalid) || (st == ST_HWR_REQ && hm_ready);
    assign last = (cnt == 64'd1);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_ptr <= '0;
            dev_ptr  <= '0;
        end else if (st == ST_CHECK) begin
            host_ptr <= host_a;
            dev_ptr  <= dev_rel[AW-1:0];
        end else if (beat) begin
            host_ptr <= host_ptr + 64'd1;
            dev_ptr  <= dev_ptr + AW'(1);
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:     if (cmd[CMD_GO]) st_nx = ST_CHECK;
            ST_CHECK: begin
                if (!(dev_ok && host_ok))  st_nx = ST_IDLE;
                else if (cnt == 64'd0)     st_nx = ST_DONE;
                else if (cmd[CMD_DIR])     st_nx = ST_HWR_REQ;
                else                       st_nx = ST_HRD_REQ;
            end
            ST_HRD_REQ:  if (hm_ready)  st_nx = ST_HRD_WAIT;
            ST_HRD_WAIT: if (hm_rvalid) st_nx = last ? ST_DONE : ST_HRD_REQ;
            ST_HWR_REQ:  if (hm_ready && last) st_nx = ST_DONE;
            ST_DONE:     st_nx = ST_IDLE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        hm_valid  = (st == ST_HRD_REQ) || (st == ST_HWR_REQ);
        hm_write  = (st == ST_HWR_REQ);
        hm_addr   = host_ptr;
        hm_wdata  = buf_rdata;
        buf_off   = dev_ptr;
        buf_we    = (st == ST_HRD_WAIT) && hm_rvalid;
        buf_wdata = hm_rdata;
        cnt_dec   = beat;
        done_clr  = (st == ST_DONE) || (st == ST_CHECK && !(dev_ok && host_ok));
        irq_valid = (st == ST_DONE) && cmd[CMD_IRQ];
        irq_cause = irq_valid ? DONE_CAUSE : 16'h0000;
    end

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        beat |-> (cnt != 64'd0));
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hm_valid && !hm_ready) |=> (hm_valid && $stable(hm_addr) && $stable(hm_write)));
    assert_host_in_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hm_valid |-> ((hm_addr & ~HMASK) == 64'd0));
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);
endmodule

// File: rtl/dma_blk_mover.sv
module dma_blk_mover
    import dma_pkg::*;
#(
    parameter int          BUF_BYTES     = 4096,
    parameter logic [63:0] BUF_BASE      = 64'h40000,
    parameter int          DMA_ADDR_BITS = 28
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_wide,
    input  logic [7:0]  reg_addr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        hm_valid,
    output logic        hm_write,
    output logic [63:0] hm_addr,
    output logic [7:0]  hm_wdata,
    input  logic        hm_ready,
    input  logic        hm_rvalid,
    input  logic [7:0]  hm_rdata,
    output logic        irq_valid,
    output logic [15:0] irq_cause
);
    localparam int AW = $clog2(BUF_BYTES);

    logic [63:0]      src_w, dst_w, cnt_w;
    logic [CMD_W-1:0] cmd_w;
    logic             cnt_dec, done_clr, buf_we;
    logic [AW-1:0]    buf_off;
    logic [7:0]       buf_wdata, buf_rdata;

    dma_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cnt_dec(cnt_dec), .done_clr(done_clr),
        .src_o(src_w), .dst_o(dst_w), .cnt_o(cnt_w), .cmd_o(cmd_w)
    );

    dma_ctrl #(
        .BUF_BYTES(BUF_BYTES), .BUF_BASE(BUF_BASE), .DMA_ADDR_BITS(DMA_ADDR_BITS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .src(src_w), .dst(dst_w), .cnt(cnt_w), .cmd(cmd_w),
        .cnt_dec(cnt_dec), .done_clr(done_clr),
        .hm_valid(hm_valid), .hm_write(hm_write), .hm_addr(hm_addr), .hm_wdata(hm_wdata),
        .hm_ready(hm_ready), .hm_rvalid(hm_rvalid), .hm_rdata(hm_rdata),
        .buf_we(buf_we), .buf_off(buf_off), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .irq_valid(irq_valid), .irq_cause(irq_cause)
    );

    dma_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
        .clk(clk), .we(buf_we), .off(buf_off), .wdata(buf_wdata), .rdata(buf_rdata)
    );

    assert_req_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hm_valid |-> cmd_w[CMD_GO]);
    assert_irq_only_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !cmd_w[CMD_GO]);
endmodule

// File: tb/dma_blk_mover_tb.sv
module dma_blk_mover_tb;
    localparam logic [63:0] BASE = 64'h40000;
    localparam int BUFN = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_wide = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        hm_valid, hm_write;
    logic [63:0] hm_addr;
    logic [7:0]  hm_wdata;
    logic        hm_ready = 1'b0, hm_rvalid = 1'b0;
    logic [7:0]  hm_rdata = 8'h0;
    logic        irq_valid;
    logic [15:0] irq_cause;

    int total = 0, bad = 0;
    int cyc = 0;
    int log_n = 0, irq_cnt = 0, irq_bad = 0, hs_bad = 0;
    logic [63:0] log_addr [256];
    logic [7:0]  log_data [256];
    logic        log_wr   [256];
    logic [7:0]  model [BUFN];
    logic        rd_pend = 1'b0, prev_wait = 1'b0;
    logic [63:0] rd_addr = '0, prev_addr = '0;
    int          rd_dly = 0;

    always #2.5 clk = ~clk;

    dma_blk_mover u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hm_valid(hm_valid), .hm_write(hm_write), .hm_addr(hm_addr), .hm_wdata(hm_wdata),
        .hm_ready(hm_ready), .hm_rvalid(hm_rvalid), .hm_rdata(hm_rdata),
        .irq_valid(irq_valid), .irq_cause(irq_cause)
    );

    function automatic logic [7:0] hbyte(input logic [63:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // host memory model: stalls, delayed read responses, logging
    always @(negedge clk) begin
        cyc++;
        if (hm_rvalid) hm_rvalid = 1'b0;
        else if (rd_pend) begin
            if (rd_dly == 0) begin
                hm_rvalid = 1'b1;
                hm_rdata  = hbyte(rd_addr);
                rd_pend   = 1'b0;
            end else rd_dly--;
        end
        if (prev_wait && (!hm_valid || hm_addr != prev_addr)) hs_bad++;
        hm_ready = ((cyc % 5) != 2) && ((cyc % 7) != 3);
        if (hm_valid && hm_ready) begin
            if (log_n < 256) begin
                log_addr[log_n] = hm_addr;
                log_data[log_n] = hm_wdata;
                log_wr[log_n]   = hm_write;
            end
            log_n++;
            if (!hm_write) begin
                rd_pend = 1'b1;
                rd_addr = hm_addr;
                rd_dly  = cyc % 3;
            end
        end
        prev_wait = hm_valid && !hm_ready;
        prev_addr = hm_addr;
        if (irq_valid) begin
            irq_cnt++;
            if (irq_cause != 16'h0100) irq_bad++;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic wide);
        @(negedge clk);
        reg_wr = 1'b1; reg_wide = wide; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [63:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(8'h98, v);
            if (!v[0]) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_xfer(input logic [63:0] host, input logic [63:0] dev, input int len,
                            input bit dir, input bit irqf, input bit ok, input string rq);
        logic [63:0] v;
        int errs;
        wr(8'h80, dir ? dev : host, 1'b1);
        wr(8'h88, dir ? host : dev, 1'b1);
        wr(8'h90, 64'(len), 1'b1);
        log_n = 0; irq_cnt = 0; irq_bad = 0;
        wr(8'h98, {61'd0, irqf, dir, 1'b1}, 1'b0);
        wait_idle();
        rd(8'h98, v);
        check(v[0] == 1'b0, "R3", "go bit after end", v, 0);
        rd(8'h90, v);
        if (ok) begin
            check(v == 0, "R6", "count at end", v, 0);
            check(log_n == len, "R11", "beats", 64'(log_n), 64'(len));
            check(irq_cnt == (irqf ? 1 : 0) && irq_bad == 0, len == 0 ? "R12" : "R7",
                  "irq posts", 64'(irq_cnt), 64'(irqf));
            errs = 0;
            for (int i = 0; i < len && i < 256; i++) begin
                if (!dir) begin
                    if (log_wr[i] || log_addr[i] != host + 64'(i)) errs++;
                    model[int'(dev - BASE) + i] = hbyte(host + 64'(i));
                end else begin
                    if (!log_wr[i] || log_addr[i] != host + 64'(i) ||
                        log_data[i] != model[int'(dev - BASE) + i]) errs++;
                end
            end
            check(errs == 0, dir ? "R5" : "R4", "byte order/data mismatches", 64'(errs), 0);
        end else begin
            check(log_n == 0, rq, "host beats on reject", 64'(log_n), 0);
            check(v == 64'(len), rq, "count on reject", v, 64'(len));
            check(irq_cnt == 0, rq, "irq on reject", 64'(irq_cnt), 0);
        end
    endtask

    initial begin
        logic [63:0] v;
        int lens [5] = '{1, 2, 5, 16, 33};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h80, v); check(v == 0, "R1", "src reset", v, 0);
        rd(8'h88, v); check(v == 0, "R1", "dst reset", v, 0);
        rd(8'h90, v); check(v == 0, "R1", "count reset", v, 0);
        rd(8'h98, v); check(v == 0, "R1", "cmd reset", v, 0);
        check(!hm_valid && !irq_valid, "R1", "idle outputs", {hm_valid, irq_valid}, 0);

        // R2 register access
        wr(8'h80, 64'h0123456789ABCDEF, 1'b1);
        rd(8'h80, v); check(v == 64'h0123456789ABCDEF, "R2", "wide write", v, 64'h0123456789ABCDEF);
        wr(8'h84, 64'hCAFEF00D, 1'b0);
        rd(8'h80, v); check(v == 64'hCAFEF00D89ABCDEF, "R2", "high-half write", v, 64'hCAFEF00D89ABCDEF);
        rd(8'h84, v); check(v == 64'hCAFEF00D, "R2", "high-half read", v, 64'hCAFEF00D);
        wr(8'h90, 64'h11111111, 1'b0);
        rd(8'h90, v); check(v == 64'h11111111, "R2", "count low write", v, 64'h11111111);
        rd(8'hA0, v); check(v == 0, "R2", "unmapped read", v, 0);
        wr(8'h98, 64'h6, 1'b0);
        rd(8'h98, v); check(v == 64'h6, "R2", "cmd no-go", v, 64'h6);
        wr(8'h98, 64'h0, 1'b0);

        // R4/R5/R6/R7 sweep
        foreach (lens[k]) begin
            int offs [3];
            offs = '{0, 777, BUFN - lens[k]};
            foreach (offs[j]) begin
                run_xfer(64'h00123000 + 64'(offs[j]) + 64'(lens[k] * 64),
                         BASE + 64'(offs[j]), lens[k], 1'b0, lens[k][0], 1'b1, "R4");
                run_xfer(64'h08000000 + 64'(offs[j]) * 2,
                         BASE + 64'(offs[j]), lens[k], 1'b1, !lens[k][0], 1'b1, "R5");
            end
        end

        // R8 device range rejects and boundary accept
        run_xfer(64'h1000, BASE + 64'(BUFN - 2), 3, 1'b0, 1'b1, 1'b0, "R8");
        run_xfer(64'h1000, BASE - 64'd1, 2, 1'b0, 1'b1, 1'b0, "R8");
        run_xfer(64'h1000, BASE + 64'(BUFN), 1, 1'b1, 1'b1, 1'b0, "R8");
        run_xfer(64'h2000, BASE + 64'(BUFN - 2), 2, 1'b0, 1'b0, 1'b1, "R8");

        // R9 host mask rejects and boundary accept
        run_xfer(64'h0FFFFFFF, BASE, 2, 1'b0, 1'b1, 1'b0, "R9");
        run_xfer(64'h10000000, BASE, 1, 1'b1, 1'b0, 1'b0, "R9");
        run_xfer(64'h0FFFFFFE, BASE, 2, 1'b0, 1'b1, 1'b1, "R9");

        // R12 zero count
        run_xfer(64'h3000, BASE + 64'd10, 0, 1'b0, 1'b1, 1'b1, "R12");

        // R10 writes while busy
        wr(8'h80, 64'h00005000, 1'b1);
        wr(8'h88, BASE + 64'd200, 1'b1);
        wr(8'h90, 64'd20, 1'b1);
        log_n = 0; irq_cnt = 0; irq_bad = 0;
        wr(8'h98, 64'h5, 1'b0);
        wr(8'h80, 64'h0, 1'b1);
        wr(8'h88, 64'h0, 1'b1);
        wr(8'h90, 64'd5, 1'b1);
        wr(8'h98, 64'h3, 1'b0);
        rd(8'h98, v); check(v == 64'h5, "R10", "cmd while busy (R3 go=1)", v, 64'h5);
        rd(8'h80, v); check(v == 64'h5000, "R10", "src while busy", v, 64'h5000);
        rd(8'h88, v); check(v == BASE + 64'd200, "R10", "dst while busy", v, BASE + 64'd200);
        wait_idle();
        rd(8'h90, v); check(v == 0, "R10", "count after busy writes", v, 0);
        check(log_n == 20 && irq_cnt == 1, "R10", "beats after busy writes", 64'(log_n), 20);
        begin
            int errs = 0;
            for (int i = 0; i < 20; i++)
                if (log_wr[i] || log_addr[i] != 64'h5000 + 64'(i)) errs++;
            check(errs == 0, "R10", "addresses after busy writes", 64'(errs), 0);
        end

        check(hs_bad == 0, "R11", "request held while stalled", 64'(hs_bad), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule